// File: doc/BRIEF.md
# Gated 22 kHz Tone Keyer

This block divides a fast system clock down to a square-wave carrier near 22 kHz. The carrier goes to an analog modulator stage that puts the tone onto a supply line. Two sources decide whether the carrier runs. A force bit in the control register turns on a continuous tone. A logic-level keying pin, driven by a microcontroller with pulse-width-keyed data, turns the tone on and off. A global output-enable bit sits above both sources and silences the carrier whenever the output path is off.

The keying pin is asynchronous, so it passes through a two-stage synchronizer before it reaches the gating logic. When the gate closes, the carrier is pulled low on the next clock and the divider returns to the start of its period. Each new burst therefore begins with a complete high half. A status output, `tone_active`, reports whether the carrier is currently running.

Top module: `tone_keyer`

## Requirements
- R1: While reset is held, and on the first cycle after it is released with every input low, `carrier` and `tone_active` are both 0.
- R2: The carrier period is DIV clock cycles, where DIV = round(CLK_HZ / TONE_HZ). With the defaults (125 MHz clock, 22 kHz target) DIV = 5682, which gives about 21.999 kHz. This is inside the 20 to 24 kHz window.
- R3: Each period starts with a high half of ceil(DIV/2) cycles followed by a low half of floor(DIV/2) cycles. An odd DIV therefore splits into halves that differ by one cycle. For example, DIV = 7 gives 4 cycles high and 3 cycles low. The duty cycle stays within 40 to 60%.
- R4: When `out_en` = 1 and `tone_force` = 1, the carrier runs continuously and `key_in` has no effect. Switching the gate on at a clock edge raises `carrier` at that same edge.
- R5: When `out_en` = 1 and `tone_force` = 0, the carrier runs while `key_in` is high and stops while it is low. A change on `key_in` reaches the outputs at the third rising clock edge after the change.
- R6: When `out_en` = 0, `carrier` and `tone_active` are 0 from the next clock edge onward, whatever the other inputs are.
- R7: When the gate closes, `carrier` goes low at the next edge. The next burst starts at phase zero with a full high half of ceil(DIV/2) cycles.
- R8: `tone_active` is 1 exactly while the gated carrier is running, and `carrier` is never 1 while `tone_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| out_en | input | 1 | Global output enable; 0 silences the carrier |
| tone_force | input | 1 | Continuous tone request; overrides `key_in` |
| key_in | input | 1 | Asynchronous keying input carrying pulse-width data |
| carrier | output | 1 | Gated square-wave carrier to the modulator |
| tone_active | output | 1 | High while the gated carrier is running |

## Verification
The hardest case to reach is a burst that restarts shortly after another burst was cut off in the middle of a period. The divider must start again at phase zero rather than resume from the phase it was at. To get there, the stimulus drops the keying pin partway through a period and raises it again a few cycles later. It then checks that the next high half has its full length on a second instance built with an odd ratio of 7, where the 4/3 split makes any leftover phase visible. A separate case holds the force bit on while the keying pin pulses, and then drops the global enable while both sources are still asserting the tone.

// File: rtl/tone_keyer.sv
module tone_keyer #(
  parameter int CLK_HZ  = 125_000_000,
  parameter int TONE_HZ = 22_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic out_en,
  input  logic tone_force,
  input  logic key_in,
  output logic carrier,
  output logic tone_active
);

  localparam int DIV = (CLK_HZ + TONE_HZ / 2) / TONE_HZ;
  localparam int HI  = DIV - DIV / 2;
  localparam int PW  = (DIV > 2) ? $clog2(DIV) : 1;

  logic          key_s1, key_s2;
  logic          run, car;
  logic [PW-1:0] ph, nph;
  logic          gate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_s1 <= 1'b0;
      key_s2 <= 1'b0;
    end else begin
      key_s1 <= key_in;
      key_s2 <= key_s1;
    end
  end

  assign gate = out_en & (tone_force | key_s2);
  assign nph  = (ph == PW'(DIV - 1)) ? '0 : ph + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || !gate) begin
      run <= 1'b0;
      ph  <= '0;
      car <= 1'b0;
    end else if (!run) begin
      run <= 1'b1;
      ph  <= '0;
      car <= 1'b1;
    end else begin
      ph  <= nph;
      car <= (nph < PW'(HI));
    end
  end

  assign carrier     = car;
  assign tone_active = run;

  // R6
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> (!carrier && !tone_active));

  // R8
  active_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carrier |-> tone_active);

  // R4
  force_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && tone_force) |=> tone_active);

  // R7
  fresh_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tone_active) |-> (carrier && ph == '0));

  // R3
  period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(carrier) && $past(tone_active)) |-> ($past(ph) == PW'(DIV - 1)));

endmodule

// File: tb/tone_keyer_test.sv
module tone_keyer_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic out_en = 1'b0;
  logic tone_force = 1'b0;
  logic key_in = 1'b0;
  logic car0, act0, car1, act1;

  always #4 clk = ~clk;

  tone_keyer uut (
    .clk(clk), .rst_n(rst_n), .out_en(out_en), .tone_force(tone_force),
    .key_in(key_in), .carrier(car0), .tone_active(act0)
  );

  tone_keyer #(.CLK_HZ(154_000), .TONE_HZ(22_000)) uut_odd (
    .clk(clk), .rst_n(rst_n), .out_en(out_en), .tone_force(tone_force),
    .key_in(key_in), .carrier(car1), .tone_active(act1)
  );

  typedef struct {
    int    stamp;
    int    dut;
    logic  car;
    logic  act;
    string tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].stamp <= cyc) begin
      item_t it;
      logic c, a;
      it = q.pop_front();
      c = (it.dut == 0) ? car0 : car1;
      a = (it.dut == 0) ? act0 : act1;
      checks++;
      if (it.stamp != cyc || c !== it.car || a !== it.act) begin
        failures++;
        $display("FAIL %s dut%0d cyc=%0d/%0d carrier=%b/%b active=%b/%b (actual/expected)",
                 it.tag, it.dut, cyc, it.stamp, c, it.car, a, it.act);
      end
    end
  end

  task automatic expect_at(int ofs, int dut, logic c, logic a, string tag);
    item_t it;
    it.stamp = cyc + ofs; it.dut = dut; it.car = c; it.act = a; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(3);
    expect_at(0, 0, 1'b0, 1'b0, "R1");
    expect_at(0, 1, 1'b0, 1'b0, "R1");
    rst_n = 1'b1;
    wait_cyc(1);
    expect_at(0, 0, 1'b0, 1'b0, "R1");
    expect_at(0, 1, 1'b0, 1'b0, "R1");
    wait_cyc(2);

    // R4, R2, R3: forced continuous tone
    out_en = 1'b1;
    tone_force = 1'b1;
    expect_at(1, 0, 1'b1, 1'b1, "R4");
    expect_at(1, 1, 1'b1, 1'b1, "R8");
    expect_at(4, 1, 1'b1, 1'b1, "R3");
    expect_at(5, 1, 1'b0, 1'b1, "R3");
    expect_at(7, 1, 1'b0, 1'b1, "R3");
    expect_at(8, 1, 1'b1, 1'b1, "R3");
    expect_at(2841, 0, 1'b1, 1'b1, "R3");
    expect_at(2842, 0, 1'b0, 1'b1, "R3");
    expect_at(5682, 0, 1'b0, 1'b1, "R2");
    expect_at(5683, 0, 1'b1, 1'b1, "R2");
    expect_at(11365, 0, 1'b1, 1'b1, "R4");
    wait_cyc(100);
    key_in = 1'b1;
    wait_cyc(100);
    key_in = 1'b0;
    wait_cyc(11800);

    // R7: gate closes, forced low at next edge
    tone_force = 1'b0;
    expect_at(1, 0, 1'b0, 1'b0, "R7");
    expect_at(1, 1, 1'b0, 1'b0, "R8");
    expect_at(50, 0, 1'b0, 1'b0, "R5");
    wait_cyc(100);

    // R5: keying with synchronizer latency, R7 fresh restart
    key_in = 1'b1;
    expect_at(2, 0, 1'b0, 1'b0, "R5");
    expect_at(3, 0, 1'b1, 1'b1, "R5");
    expect_at(6, 1, 1'b1, 1'b1, "R3");
    expect_at(7, 1, 1'b0, 1'b1, "R3");
    expect_at(10, 1, 1'b1, 1'b1, "R5");
    expect_at(22, 0, 1'b1, 1'b1, "R5");
    expect_at(23, 0, 1'b0, 1'b0, "R5");
    expect_at(23, 1, 1'b0, 1'b0, "R7");
    expect_at(33, 1, 1'b1, 1'b1, "R7");
    expect_at(36, 1, 1'b1, 1'b1, "R7");
    expect_at(37, 1, 1'b0, 1'b1, "R7");
    wait_cyc(20);
    key_in = 1'b0;
    wait_cyc(10);
    key_in = 1'b1;
    wait_cyc(70);

    // R6: global enable off overrides both sources
    tone_force = 1'b1;
    out_en = 1'b0;
    expect_at(1, 0, 1'b0, 1'b0, "R6");
    expect_at(1, 1, 1'b0, 1'b0, "R6");
    expect_at(400, 0, 1'b0, 1'b0, "R6");
    expect_at(400, 1, 1'b0, 1'b0, "R6");
    wait_cyc(500);
    out_en = 1'b1;
    expect_at(1, 0, 1'b1, 1'b1, "R4");
    expect_at(1, 1, 1'b1, 1'b1, "R4");
    wait_cyc(20);

    while (q.size() > 0) wait_cyc(1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired pending=%0d expected=0", q.size());
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule